// File: doc/BRIEF.md
# Selectable Buzzer Tone Generator

This block drives a piezo buzzer with a square wave. The wave is made by dividing a 4 MHz reference clock. A 3-bit tone code picks one of eight pitches between 1 kHz and 4 kHz. The divisors for these pitches are irregular, so they come from a fixed lookup rather than from a power-of-two prescaler. Software turns the tone on with an enable bit.

There is also a hardware auto-beep path for continuity and diode checks. When this path is armed, an active-low short-detect comparator input sounds the buzzer with no firmware action. That input comes from the analog side, so it passes through a two-stage synchroniser before it is used.

The output is one registered pin. It rests low whenever the tone is off. A tone code written while the tone is running waits for the end of the current period before it takes effect, so no runt pulse appears.

Top module: `buzzer_tone_gen`

## Requirements
- R1: While `rst` is high, `buzz_out` is 0. After reset the divider is cleared.
- R2: While the tone runs, `buzz_out` is a 50 % duty square wave. Each half period lasts the number of `clk` cycles set by `tone_sel`: 0→2000, 1→1500, 2→1000, 3→900, 4→750, 5→650, 6→600, 7→500. At 4 MHz these give 1.00, 1.33, 2.00, 2.22, 2.67, 3.08, 3.33 and 4.00 kHz.
- R3: The tone runs while `sw_enable` is 1. The first rising edge of `buzz_out` follows exactly one half period after the first clock edge that samples `sw_enable` high.
- R4: When the tone stops running, `buzz_out` is 0 after the next clock edge and the divider is cleared. A later start produces a full first half period again.
- R5: A new `tone_sel` is taken only when `buzz_out` falls, which is the period boundary, or when the tone is idle. A period already in progress completes with its old half-period length.
- R6: With `auto_enable` = 1 and `short_n` = 0, the tone runs without `sw_enable`. `short_n` passes through two synchroniser flops, so the divider reacts on the third clock edge after a change of `short_n`.
- R7: `short_n` has no effect while `auto_enable` = 0. `auto_enable` has no effect while `short_n` = 1. In both cases, with `sw_enable` = 0, `buzz_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tone_sel | input | 3 | Tone code, 0 (lowest pitch) to 7 (highest) |
| sw_enable | input | 1 | Software tone enable |
| auto_enable | input | 1 | Arms the hardware auto-beep path |
| short_n | input | 1 | Asynchronous short-detect comparator output, active low |
| buzz_out | output | 1 | Buzzer drive, low when silent |

## Verification
Each of the eight codes is started from idle. The bench measures the delay to the first rising edge and the high and low widths, which separates a wrong table entry from an off-by-one in the terminal count or an uneven duty. Code changes are made in the high phase and again in the low phase. The resulting widths show whether the reload happens at the falling boundary or at some other point.

Stopping during a high phase and restarting shows whether the output is forced low and the divider is cleared. The auto path is driven with `short_n` pulsed against each setting of `auto_enable`. These runs confirm the two-flop latency and show that the input is masked when the path is not armed.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int CODE_W   = 3;
  localparam int MAX_HALF = 2000;
  localparam int CNT_W    = $clog2(MAX_HALF + 1);

  // Half-period length in reference clock cycles for each tone code.
  function automatic int tone_half(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    tone_half = 2000;
      3'd1:    tone_half = 1500;
      3'd2:    tone_half = 1000;
      3'd3:    tone_half = 900;
      3'd4:    tone_half = 750;
      3'd5:    tone_half = 650;
      3'd6:    tone_half = 600;
      default: tone_half = 500;
    endcase
  endfunction
endpackage

// File: rtl/tone_sync.sv
module tone_sync #(
  parameter int STAGES   = 2,
  parameter bit IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= {STAGES{IDLE_VAL}};
    else     pipe_q <= {pipe_q[STAGES-2:0], async_i};
  end

  assign sync_o = pipe_q[STAGES-1];

  // R6: the last stage repeats the previous stage one cycle later
  a_r6_sync_shift: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sync_o == $past(pipe_q[STAGES-2]));
endmodule

// File: rtl/tone_gate.sv
module tone_gate (
  input  logic sw_enable,
  input  logic auto_enable,
  input  logic short_sync_n,
  output logic run
);
  always_comb run = sw_enable | (auto_enable & ~short_sync_n);
endmodule

// File: rtl/tone_divider.sv
module tone_divider #(
  parameter int CODE_W = tone_pkg::CODE_W,
  parameter int CNT_W  = tone_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CODE_W-1:0] code_in,
  output logic              wave
);
  logic [CODE_W-1:0] cur_code;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  half_m1;
  logic              wave_q;
  logic              tog;

  always_comb begin
    half_m1 = CNT_W'(tone_pkg::tone_half(cur_code) - 1);
    tog     = run && (cnt == half_m1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      wave_q   <= 1'b0;
      cur_code <= '0;
    end else if (!run) begin
      cnt      <= '0;
      wave_q   <= 1'b0;
      cur_code <= code_in;
    end else if (tog) begin
      cnt    <= '0;
      wave_q <= ~wave_q;
      if (wave_q) cur_code <= code_in;  // falling edge closes the period
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign wave = wave_q;

  // R4: no run means a low output after the edge
  a_r4_idle_low: assert property (@(posedge clk) disable iff (rst)
    !run |=> !wave_q);
  // R2: the output only moves when the count reaches its terminal value
  a_r2_toggle_at_end: assert property (@(posedge clk) disable iff (rst)
    (run && cnt != half_m1) |=> $stable(wave_q));
  // R2: the counter never passes the half period
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= half_m1);
  // R5: the code is held inside a period
  a_r5_code_hold: assert property (@(posedge clk) disable iff (rst)
    (run && !(tog && wave_q)) |=> $stable(cur_code));
endmodule

// File: rtl/buzzer_tone_gen.sv
module buzzer_tone_gen #(
  parameter int CODE_W      = tone_pkg::CODE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] tone_sel,
  input  logic              sw_enable,
  input  logic              auto_enable,
  input  logic              short_n,
  output logic              buzz_out
);
  localparam int CNT_W = tone_pkg::CNT_W;

  logic short_sync_n;
  logic run;

  tone_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .async_i(short_n), .sync_o(short_sync_n)
  );

  tone_gate u_gate (
    .sw_enable(sw_enable), .auto_enable(auto_enable),
    .short_sync_n(short_sync_n), .run(run)
  );

  tone_divider #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_div (
    .clk(clk), .rst(rst), .run(run), .code_in(tone_sel), .wave(buzz_out)
  );

  // R1: output low right after a reset edge
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> !buzz_out);
  // R7: with both enables off the output is low
  a_r7_all_off: assert property (@(posedge clk) disable iff (rst)
    (!sw_enable && !auto_enable) |=> !buzz_out);
endmodule

// File: tb/buzzer_tone_gen_tb.sv
`timescale 1ns/1ps
module buzzer_tone_gen_tb;
  localparam int CLK_PERIOD = 250;
  localparam int HALVES [8] = '{2000, 1500, 1000, 900, 750, 650, 600, 500};
  localparam int WD_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] tone_sel = '0;
  logic       sw_enable = 1'b0;
  logic       auto_enable = 1'b0;
  logic       short_n = 1'b1;
  logic       buzz_out;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buzzer_tone_gen u_dut (
    .clk(clk), .rst(rst), .tone_sel(tone_sel), .sw_enable(sw_enable),
    .auto_enable(auto_enable), .short_n(short_n), .buzz_out(buzz_out)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_until(input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (buzz_out !== lvl && n < 5000);
  endtask

  task automatic high_samples(input int cycles, output int hits);
    hits = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (buzz_out !== 1'b0) hits++;
    end
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    chk("R1 low in reset", int'(buzz_out), 0);
    rst = 1'b0;
    high_samples(20, n);
    chk("R7 idle after reset", n, 0);

    // Table walk: first rise, high width, low width per code
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sw_enable = 1'b0;
      tone_sel = 3'(i);
      @(negedge clk);
      sw_enable = 1'b1;
      count_until(1'b1, n);
      chk($sformatf("R3 first rise code %0d", i), n, HALVES[i]);
      count_until(1'b0, n);
      chk($sformatf("R2 high width code %0d", i), n, HALVES[i]);
      count_until(1'b1, n);
      chk($sformatf("R2 low width code %0d", i), n, HALVES[i]);
    end

    // R4: stop during high, then restart from a cleared divider
    sw_enable = 1'b0;
    @(negedge clk);
    chk("R4 forced low", int'(buzz_out), 0);
    sw_enable = 1'b1;
    count_until(1'b1, n);
    chk("R4 full first half after restart", n, 500);

    // R5: change during high phase of code 7
    tone_sel = 3'd0;
    count_until(1'b0, n);
    chk("R5 high keeps old length", n, 500);
    count_until(1'b1, n);
    chk("R5 new low length", n, 2000);
    count_until(1'b0, n);
    chk("R5 new high length", n, 2000);
    // R5: change during low phase keeps the whole period
    tone_sel = 3'd6;
    count_until(1'b1, n);
    chk("R5 low in progress kept", n, 2000);
    count_until(1'b0, n);
    chk("R5 high of same period kept", n, 2000);
    count_until(1'b1, n);
    chk("R5 next low uses new code", n, 600);

    // R7: armed path with inactive short stays silent
    sw_enable = 1'b0;
    tone_sel = 3'd7;
    auto_enable = 1'b1;
    short_n = 1'b1;
    high_samples(1200, n);
    chk("R7 short inactive silent", n, 0);

    // R6: short asserted, two sync flops then half period
    short_n = 1'b0;
    count_until(1'b1, n);
    chk("R6 auto start latency", n, 502);
    short_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R6 still high two cycles after release", int'(buzz_out), 1);
    @(negedge clk);
    chk("R6 low three cycles after release", int'(buzz_out), 0);

    // R7: short asserted but path not armed
    auto_enable = 1'b0;
    short_n = 1'b0;
    high_samples(1200, n);
    chk("R7 unarmed short silent", n, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule